// File: doc/BRIEF.md
# Serial High-Throughput Signal Field CRC-8 Checker

This block validates the 48-bit high-throughput signal field of an 802.11n receive chain. It sits after the convolutional decoder and receives the decoded field one bit per valid strobe. A start pulse opens a new field. The first 34 protected bits pass through an 8-stage CRC shift register that is preset to all ones. The next 8 bits are the received CRC, and each one is compared with the matching complemented register stage as it arrives. The last 6 bits are tail bits, and they must all be zero.

When the 48th bit has been taken, the block raises a one-cycle done strobe. It then holds two verdicts, one for the CRC and one for the tail. Both stay unchanged until the next start pulse, so a downstream parser can sample them at leisure. The block does not interpret the MCS, length or any other field content.

Top module: `htsig_crc_check`

## Requirements
- R1: On each accepted protected bit m (bit_i, 1 = logic one), with f = C7 xor m, the register updates to C0 = f, C1 = C0 xor f, C2 = C1 xor f, and Ck = Ck-1 for k = 3..7. The register is preset to 8'hFF and advances for exactly the first 34 accepted bits of a field.
- R2: Accepted bits 35 to 42 of a field are the received CRC. The n-th of them (n = 0..7) must equal NOT C(7-n) of the register after the 34th update, so NOT C7 comes first. crc_ok_o ends high only if all 8 match. Any mismatch drives it low for the rest of the field.
- R3: Accepted bits 43 to 48 are tail bits. tail_ok_o ends high only if all six are 0.
- R4: A bit is accepted only in a cycle where bit_valid_i is high, a field is open and start_i is low. Cycles with bit_valid_i low change nothing, so gaps between bits do not alter the verdicts.
- R5: start_i re-presets the register, returns the bit count to zero, and sets crc_ok_o and tail_ok_o high in the next cycle, even in the middle of a field. A bit presented in the same cycle as start_i is not accepted.
- R6: done_o is high for exactly one cycle, namely the cycle after the 48th accepted bit. It is low at all other times.
- R7: After done_o, crc_ok_o and tail_ok_o hold their values until the next start_i.
- R8: A synchronous active-high rst sets done_o, crc_ok_o and tail_ok_o low, with no field open.
- R9: Bits that arrive while no field is open (after reset or after done, before a start) are ignored. They neither pulse done_o nor change crc_ok_o or tail_ok_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that opens a new field |
| bit_valid_i | input | 1 | Qualifies bit_i in this cycle |
| bit_i | input | 1 | Serial field bit, first bit of the field first |
| done_o | output | 1 | One-cycle strobe after the last field bit |
| crc_ok_o | output | 1 | Received CRC matched the computed one |
| tail_ok_o | output | 1 | All tail bits were zero |

## Verification
On every cycle, the assertions check that done_o lasts a single cycle and never follows a cycle with no open field. They also check that a start leaves both verdicts high and done low, that a cleared verdict stays cleared without a start, and that the verdicts hold after done. The bit counter is checked to stay inside the field length. Whether the CRC arithmetic, the complemented most-significant-first ordering and the tail rule give the right verdict for given data can only be shown by the bench. It does this with reference CRCs computed from the update equations, with flipped CRC bits at both ends of the CRC slot, with set tail bits, with gapped bit strobes, with a restart in mid-field and with bits sent while no field is open.

// File: rtl/htsig_crc_pkg.sv
package htsig_crc_pkg;

    localparam int PROT_BITS  = 34;
    localparam int CRC_W      = 8;
    localparam int TAIL_BITS  = 6;
    localparam int FIELD_BITS = PROT_BITS + CRC_W + TAIL_BITS;
    localparam int CNT_W      = $clog2(FIELD_BITS);
    localparam int IDX_W      = $clog2(CRC_W);

    typedef enum logic [1:0] {
        SEG_PROT = 2'd0,
        SEG_CRC  = 2'd1,
        SEG_TAIL = 2'd2
    } seg_e;

    // One serial update of the CRC-8 register (taps on stages 0, 1, 2).
    function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c,
                                                  input logic m);
        logic fb;
        logic [CRC_W-1:0] n;
        fb = c[CRC_W-1] ^ m;
        n  = {c[CRC_W-2:0], fb};
        n[1] = c[0] ^ fb;
        n[2] = c[1] ^ fb;
        return n;
    endfunction

endpackage

// File: rtl/htsig_crc_lfsr.sv
module htsig_crc_lfsr
    import htsig_crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             preset_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] reg_o
);

    typedef struct packed {
        logic [CRC_W-1:0] c;
    } lfsr_t;

    lfsr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (preset_i) begin
            st_d.c = '1;
        end else if (shift_i) begin
            st_d.c = crc_next(st_q.c, bit_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.c <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_o = st_q.c;

endmodule

// File: rtl/htsig_field_seq.sv
module htsig_field_seq
    import htsig_crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             bit_valid_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             take_o,
    output logic             last_o,
    output seg_e             seg_o,
    output logic [IDX_W-1:0] crc_idx_o
);

    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(FIELD_BITS - 1);
    localparam logic [CNT_W-1:0] CRC_START = CNT_W'(PROT_BITS);
    localparam logic [CNT_W-1:0] TAIL_START = CNT_W'(PROT_BITS + CRC_W);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;
    logic take;
    logic last;
    logic [CNT_W-1:0] crc_off;

    always_comb begin
        take    = st_q.busy && bit_valid_i && !start_i;
        last    = take && (st_q.cnt == LAST_IDX);
        crc_off = st_q.cnt - CRC_START;
        st_d    = st_q;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (take) begin
            if (last) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_comb begin
        if (st_q.cnt < CRC_START) begin
            seg_o = SEG_PROT;
        end else if (st_q.cnt < TAIL_START) begin
            seg_o = SEG_CRC;
        end else begin
            seg_o = SEG_TAIL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign cnt_o     = st_q.cnt;
    assign take_o    = take;
    assign last_o    = last;
    assign crc_idx_o = crc_off[IDX_W-1:0];

endmodule

// File: rtl/htsig_crc_check.sv
module htsig_crc_check
    import htsig_crc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic bit_valid_i,
    input  logic bit_i,
    output logic done_o,
    output logic crc_ok_o,
    output logic tail_ok_o
);

    typedef struct packed {
        logic crc_ok;
        logic tail_ok;
        logic done;
    } verdict_t;

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             take;
    logic             last;
    seg_e             seg;
    logic [IDX_W-1:0] crc_idx;
    logic [CRC_W-1:0] crc_reg;
    logic             exp_bit;
    verdict_t         st_d, st_q;

    htsig_field_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .bit_valid_i (bit_valid_i),
        .busy_o      (busy),
        .cnt_o       (cnt),
        .take_o      (take),
        .last_o      (last),
        .seg_o       (seg),
        .crc_idx_o   (crc_idx)
    );

    htsig_crc_lfsr u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .preset_i (start_i),
        .shift_i  (take && (seg == SEG_PROT)),
        .bit_i    (bit_i),
        .reg_o    (crc_reg)
    );

    // CRC bits leave highest stage first, each complemented.
    assign exp_bit = ~crc_reg[(CRC_W-1) - int'(crc_idx)];

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.crc_ok  = 1'b1;
            st_d.tail_ok = 1'b1;
        end else if (take) begin
            if ((seg == SEG_CRC) && (bit_i != exp_bit)) begin
                st_d.crc_ok = 1'b0;
            end
            if ((seg == SEG_TAIL) && bit_i) begin
                st_d.tail_ok = 1'b0;
            end
            st_d.done = last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.crc_ok  <= 1'b0;
            st_q.tail_ok <= 1'b0;
            st_q.done    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = st_q.done;
    assign crc_ok_o  = st_q.crc_ok;
    assign tail_ok_o = st_q.tail_ok;

endmodule

// File: rtl/htsig_crc_check_sva.sv
module htsig_crc_check_sva
    import htsig_crc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             done_o,
    input logic             crc_ok_o,
    input logic             tail_ok_o,
    input logic             busy,
    input logic [CNT_W-1:0] cnt
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6

    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy) |=> !done_o); // R9

    AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (crc_ok_o && tail_ok_o && !done_o && busy)); // R5

    AST_CRC_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!crc_ok_o && !start_i) |=> !crc_ok_o); // R2

    AST_TAIL_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!tail_ok_o && !start_i) |=> !tail_ok_o); // R3

    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> ($stable(crc_ok_o) && $stable(tail_ok_o))); // R7

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(FIELD_BITS)); // R4

endmodule

bind htsig_crc_check htsig_crc_check_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .done_o    (done_o),
    .crc_ok_o  (crc_ok_o),
    .tail_ok_o (tail_ok_o),
    .busy      (busy),
    .cnt       (cnt)
);

// File: tb/htsig_crc_check_tb.sv
module htsig_crc_check_tb_top;

    logic clk = 1'b0;
    logic rst;
    logic start_i;
    logic bit_valid_i;
    logic bit_i;
    logic done_o;
    logic crc_ok_o;
    logic tail_ok_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2 clk = ~clk; // 250 MHz

    htsig_crc_check dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .bit_valid_i (bit_valid_i),
        .bit_i       (bit_i),
        .done_o      (done_o),
        .crc_ok_o    (crc_ok_o),
        .tail_ok_o   (tail_ok_o)
    );

    // entry: {data[33:0] (bit i = m_i), crc flip mask[7:0] (bit n flips CRC bit n), tail[5:0]}, then gap
    localparam int NVEC = 8;
    localparam logic [47:0] VEC [NVEC] = '{
        {34'h0_0000_0000, 8'h00, 6'h00},
        {34'h3_FFFF_FFFF, 8'h00, 6'h00},
        {34'h1_2345_6789, 8'h00, 6'h00},
        {34'h2_A5A5_5A5A, 8'h01, 6'h00},
        {34'h0_DEAD_BEEF, 8'h80, 6'h00},
        {34'h1_0F0F_F0F0, 8'h00, 6'h20},
        {34'h3_C001_0002, 8'h00, 6'h01},
        {34'h0_8000_0001, 8'h18, 6'h3F}
    };
    localparam int GAP [NVEC] = '{0, 1, 0, 2, 0, 3, 0, 1};

    function automatic logic [7:0] ref_crc(input logic [33:0] d);
        logic [7:0] c;
        logic f;
        c = 8'hFF;
        for (int i = 0; i < 34; i++) begin
            f = c[7] ^ d[i];
            c = {c[6], c[5], c[4], c[3], c[2], c[1] ^ f, c[0] ^ f, f};
        end
        return ~c;
    endfunction

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic with_bit);
        @(negedge clk);
        start_i     = 1'b1;
        bit_valid_i = with_bit;
        bit_i       = with_bit;
        @(negedge clk);
        start_i     = 1'b0;
        bit_valid_i = 1'b0;
        bit_i       = 1'b0;
    endtask

    // Sends `nbits` bits of a field; done must stay low until after the last one.
    task automatic send_bits(input logic [33:0] d, input logic [7:0] flip,
                             input logic [5:0] tail, input int gap,
                             input int nbits, output logic early);
        logic [7:0] crc;
        logic b;
        crc   = ref_crc(d);
        early = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            if (i < 34)      b = d[i];
            else if (i < 42) b = crc[7-(i-34)] ^ flip[i-34];
            else             b = tail[i-42];
            @(negedge clk);
            if (done_o) early = 1'b1;
            bit_valid_i = 1'b1;
            bit_i       = b;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                if (done_o) early = 1'b1;
                bit_valid_i = 1'b0;
                bit_i       = ~b;
            end
        end
        @(negedge clk);
        bit_valid_i = 1'b0;
        bit_i       = 1'b0;
    endtask

    task automatic run_field(input string req, input logic [33:0] d,
                             input logic [7:0] flip, input logic [5:0] tail,
                             input int gap);
        logic early;
        pulse_start(1'b0);
        send_bits(d, flip, tail, gap, 48, early);
        // if gap>0 the last bit was followed by gap idle cycles already
        if (gap == 0) begin
            check(req, "R6 done after 48th bit", done_o, 1'b1);
        end else begin
            check(req, "R6 done after 48th bit (gapped)", early, 1'b1);
        end
        check(req, "R2 crc_ok", crc_ok_o, flip == 8'h00);
        check(req, "R3 tail_ok", tail_ok_o, tail == 6'h00);
        @(negedge clk);
        check(req, "R6 done one cycle", done_o, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic early;
        logic ok_c;
        logic ok_t;
        rst         = 1'b1;
        start_i     = 1'b0;
        bit_valid_i = 1'b0;
        bit_i       = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8", "done after reset", done_o, 1'b0);
        check("R8", "crc_ok after reset", crc_ok_o, 1'b0);
        check("R8", "tail_ok after reset", tail_ok_o, 1'b0);

        // R9: a whole field's worth of bits with no start
        send_bits(34'h1_2345_6789, 8'h00, 6'h00, 0, 48, early);
        check("R9", "no done while idle (during)", early, 1'b0);
        check("R9", "no done while idle (after)", done_o, 1'b0);
        check("R9", "crc_ok unchanged while idle", crc_ok_o, 1'b0);

        // Table walk: R1 R2 R3 R4 R6 (gapped entries exercise R4)
        for (int v = 0; v < NVEC; v++) begin
            run_field("R1/R2/R3/R4", VEC[v][47:14], VEC[v][13:6],
                      VEC[v][5:0], GAP[v]);
        end

        // R7 + R9: stray bits after done leave verdicts unchanged
        run_field("R2", 34'h2_0000_1111, 8'h40, 6'h00, 0);
        ok_c = crc_ok_o;
        ok_t = tail_ok_o;
        send_bits(34'h3_FFFF_FFFF, 8'h00, 6'h3F, 0, 48, early);
        repeat (4) @(negedge clk);
        check("R7", "crc_ok held after done", crc_ok_o, ok_c);
        check("R7", "tail_ok held after done", tail_ok_o, ok_t);
        check("R9", "no done from stray bits", early | done_o, 1'b0);

        // R5: restart in mid-field after corrupt CRC and tail
        pulse_start(1'b0);
        send_bits(34'h1_1111_1111, 8'hFF, 6'h3F, 0, 46, early);
        check("R5", "no done in aborted field", early | done_o, 1'b0);
        check("R5", "crc_ok low in aborted field", crc_ok_o, 1'b0);
        pulse_start(1'b0);
        check("R5", "crc_ok set by start", crc_ok_o, 1'b1);
        check("R5", "tail_ok set by start", tail_ok_o, 1'b1);
        send_bits(34'h0_CAFE_0042, 8'h00, 6'h00, 0, 48, early);
        check("R5", "done after restarted field", done_o, 1'b1);
        check("R5", "crc_ok after restart", crc_ok_o, 1'b1);
        check("R5", "tail_ok after restart", tail_ok_o, 1'b1);

        // R5: bit on the start cycle is not accepted
        pulse_start(1'b1);
        send_bits(34'h2_1357_9BDF, 8'h00, 6'h00, 0, 48, early);
        check("R5", "start-cycle bit ignored (done)", done_o, 1'b1);
        check("R5", "start-cycle bit ignored (crc)", crc_ok_o, 1'b1);
        check("R5", "start-cycle bit ignored (tail)", tail_ok_o, 1'b1);

        // R1: CRC mismatch on last bit (NOT C0)
        run_field("R1", 34'h0_0000_0001, 8'h80, 6'h00, 0);

        // R8: reset in mid-field
        pulse_start(1'b0);
        send_bits(34'h0_0000_0000, 8'h00, 6'h00, 0, 20, early);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        send_bits(34'h0_0000_0000, 8'h00, 6'h00, 0, 30, early);
        check("R8", "no done after reset mid-field", early | done_o, 1'b0);
        check("R8", "crc_ok low after reset mid-field", crc_ok_o, 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule